// File: doc/BRIEF.md
# Per-Bit Configurable I/O Port

This block is an 8-bit general-purpose port seen by software as three byte-wide registers at consecutive offsets: an output-value register, a direction register and a read-only view of the pin levels. Each pin's pad behaviour comes from its direction bit and its value bit taken together. A pin can be a floating input, an input with a weak pull-up, a driven low or a driven high. The block produces per-pin output-enable, output-value and pull-up-enable signals for the pad ring.

Some pins are input-only. They are picked by a parameter mask, which by default selects bits 6 and 7. On those pins a direction write of one is dropped, the direction bit reads back as zero, and the pad is never driven or pulled up. Pin levels pass through a two-flop synchronizer before software can read them. One value bit, bit 7 by default, also serves as a halt strobe: a write to the value register with that bit at one gives a single-cycle halt request. The bit itself is stored and read back as written.

Top module: `gpio_bit_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the value and direction registers clear, so after that edge `pad_oe`, `pad_out`, `pad_pull_en` and `halt_req` are all zero and offsets 0 and 1 read 0x00.
- R2: For each pin, with direction bit d and value bit v, the pad mode is: d=0,v=0 floating input (oe=0, pull=0); d=0,v=1 pulled-up input (oe=0, pull=1); d=1,v=0 drive low (oe=1, out=0); d=1,v=1 drive high (oe=1, out=1). `pad_out` is 0 on every pin whose `pad_oe` is 0.
- R3: A write (`sel`=1, `wr`=1) to offset 0 stores all eight bits of `wdata` in the value register at that clock edge, and reading offset 0 returns them.
- R4: A write to offset 1 stores `wdata` in the direction register with the input-only bits (mask 0xC0, bits 6 and 7) forced to zero, and reading offset 1 returns zero on those bits.
- R5: Reading offset 2 returns the pin levels through two flops: a change on `pin_in` before rising edge k is not visible after edge k and is visible after edge k+1.
- R6: A write to offset 2 or offset 3 changes neither register: the pad outputs and the read-back of offsets 0 and 1 stay the same.
- R7: `halt_req` is high for exactly the one cycle after a clock edge that accepted a write to offset 0 with `wdata[7]`=1. A write with bit 7 at zero, or a write to any other offset, gives no pulse.
- R8: Input-only pins never have `pad_oe` or `pad_pull_en` high, whatever their value bit holds.
- R9: Reading offset 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | Write when high, together with `sel` |
| addr | input | 2 | Register offset: 0 value, 1 direction, 2 pin levels, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pull_en | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | Single-cycle halt request |

## Verification
The assertions check on every cycle that input-only pins are never driven or pulled up. They also check that drive and pull-up never meet on the same pin, that `halt_req` never lasts two cycles and always follows a qualifying write, and that pad outputs follow the value and direction writes and stay put across writes to offsets 2 and 3. Only the bench scenarios show the full mode table over mixed bit patterns, the read-back of every offset, the exact two-edge delay of the pin path, and the reset values.

// File: rtl/gpio_port_pkg.sv
// Shared types for the configurable I/O port.
// Assumes a 2-bit register offset space.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OFS_VALUE = 2'd0,
        OFS_DIR   = 2'd1,
        OFS_PINS  = 2'd2,
        OFS_SPARE = 2'd3
    } port_ofs_e;

    typedef struct packed {
        logic value_we;
        logic dir_we;
    } port_wr_s;

endpackage

// File: rtl/gpio_reg_decode.sv
// Turns an access strobe and offset into per-register write enables.
// Assumes writes to offsets 2 and 3 are to be dropped.
module gpio_reg_decode
    import gpio_port_pkg::*;
(
    input  logic       sel,
    input  logic       wr,
    input  logic [1:0] addr,
    output port_wr_s   wr_en
);

    // Decode the write target.
    always_comb begin
        wr_en = '0;
        if (sel && wr) begin
            case (port_ofs_e'(addr))
                OFS_VALUE: wr_en.value_we = 1'b1;
                OFS_DIR:   wr_en.dir_we   = 1'b1;
                default:   wr_en          = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
// Multi-flop synchronizer for the pin levels.
// Assumes STAGES >= 1 and that each pin is synchronized on its own.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_next
            // Pass the level on one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_mode.sv
// Maps each pin's direction and value bits to pad controls.
// Assumes the direction bits of input-only pins are already zero.
module gpio_pad_mode #(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] value_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pull_en
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (INPUT_ONLY_MASK[b]) begin : g_in_only
            // An input-only pin never drives or pulls.
            always_comb begin
                pad_oe[b]      = 1'b0;
                pad_out[b]     = 1'b0;
                pad_pull_en[b] = 1'b0;
            end
        end else begin : g_io
            // Two-bit mode: direction selects drive, value selects level or pull.
            always_comb begin
                pad_oe[b]      = dir_q[b];
                pad_out[b]     = dir_q[b] & value_q[b];
                pad_pull_en[b] = ~dir_q[b] & value_q[b];
            end
        end
    end

endmodule

// File: rtl/gpio_bit_port.sv
// Byte-wide I/O port with per-pin direction and value registers,
// synchronized pin read-back and a halt strobe on one value bit.
// Assumes a single clock and synchronous active-low reset.
module gpio_bit_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0,
    parameter int               HALT_BIT        = 7,
    parameter int               SYNC_STAGES     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pull_en,
    output logic             halt_req
);

    localparam logic [WIDTH-1:0] DIR_KEEP = ~INPUT_ONLY_MASK;

    port_wr_s         wr_en;
    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic             halt_q;

    gpio_reg_decode u_dec (
        .sel   (sel),
        .wr    (wr),
        .addr  (addr),
        .wr_en (wr_en)
    );

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_pad_mode #(.WIDTH(WIDTH), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)) u_pad (
        .dir_q       (dir_q),
        .value_q     (value_q),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_en (pad_pull_en)
    );

    // Value register, all bits stored as written.
    always_ff @(posedge clk) begin
        if (!rst_n)              value_q <= '0;
        else if (wr_en.value_we) value_q <= wdata;
    end

    // Direction register, input-only bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            dir_q <= '0;
        else if (wr_en.dir_we) dir_q <= wdata & DIR_KEEP;
    end

    // One-cycle halt request on a value write with the halt bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= wr_en.value_we & wdata[HALT_BIT];
    end

    assign halt_req = halt_q;

    // Read mux over the four offsets.
    always_comb begin
        case (port_ofs_e'(addr))
            OFS_VALUE: rdata = value_q;
            OFS_DIR:   rdata = dir_q;
            OFS_PINS:  rdata = pin_sync;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bit_port_chk.sv
// Property checker for the I/O port, bound to every instance.
// Assumes the port names of gpio_bit_port.
module gpio_bit_port_chk #(
    parameter int               WIDTH           = 8,
    parameter logic [WIDTH-1:0] INPUT_ONLY_MASK = 8'hC0,
    parameter int               HALT_BIT        = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             wr,
    input logic [1:0]       addr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pull_en,
    input logic             halt_req
);

    // R8
    in_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pull_en) & INPUT_ONLY_MASK) == '0);

    // R2
    drive_pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_pull_en) == '0) && ((pad_out & ~pad_oe) == '0));

    // R7
    halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req);

    // R7
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(sel && wr && addr == 2'd0 && wdata[HALT_BIT]));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == 2'd1) |=> (pad_oe == ($past(wdata) & ~INPUT_ONLY_MASK)));

    // R3
    value_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == 2'd0) |=> (pad_out == ($past(wdata) & pad_oe)));

    // R6
    spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr[1]) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull_en)));

endmodule

bind gpio_bit_port gpio_bit_port_chk #(
    .WIDTH(WIDTH), .INPUT_ONLY_MASK(INPUT_ONLY_MASK), .HALT_BIT(HALT_BIT)
) u_chk (.*);

// File: tb/tb_gpio_bit_port.sv
module tb_gpio_bit_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pull_en;
    logic       halt_req;

    int total = 0;
    int bad = 0;

    gpio_bit_port dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pull_en(pad_pull_en), .halt_req(halt_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {dir write, value write, exp oe, exp out, exp pull}, mask 0xC0
    localparam logic [39:0] VEC [4] = '{
        {8'hFF, 8'hA5, 8'h3F, 8'h25, 8'h00},
        {8'h0F, 8'h33, 8'h0F, 8'h03, 8'h30},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'h3F},
        {8'h55, 8'h0F, 8'h15, 8'h05, 8'h0A}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; returns halt_req seen after the write edge.
    task automatic do_write(input logic [1:0] a, input logic [7:0] d, output logic h);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        h = halt_req;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic h;
        logic [7:0] rd;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pull", pad_pull_en, 8'h00);
        check("R1 halt", {7'd0, halt_req}, 8'h00);
        do_read(2'd0, rd); check("R1 value", rd, 8'h00);
        do_read(2'd1, rd); check("R1 dir", rd, 8'h00);
        rst_n = 1'b1;

        // R2 R3 R4 table walk
        foreach (VEC[i]) begin
            do_write(2'd1, VEC[i][39:32], h);
            do_write(2'd0, VEC[i][31:24], h);
            check("R7 halt after value write", {7'd0, h}, {7'd0, VEC[i][31]});
            @(negedge clk);
            check("R7 halt one cycle", {7'd0, halt_req}, 8'h00);
            check("R2 oe", pad_oe, VEC[i][23:16]);
            check("R2 out", pad_out, VEC[i][15:8]);
            check("R2 R8 pull", pad_pull_en, VEC[i][7:0]);
            do_read(2'd0, rd); check("R3 value readback", rd, VEC[i][31:24]);
            do_read(2'd1, rd); check("R4 dir readback", rd, VEC[i][23:16]);
        end

        // R6 writes to offsets 2 and 3 ignored (state: dir 15, value 0F)
        do_write(2'd2, 8'hFF, h);
        check("R7 no halt on offset 2", {7'd0, h}, 8'h00);
        do_write(2'd3, 8'hC3, h);
        check("R6 oe", pad_oe, 8'h15);
        check("R6 pull", pad_pull_en, 8'h0A);
        do_read(2'd0, rd); check("R6 value", rd, 8'h0F);
        do_read(2'd1, rd); check("R6 dir", rd, 8'h15);

        // R9 spare offset
        do_read(2'd3, rd); check("R9 spare reads zero", rd, 8'h00);

        // R7 bit 7 write with 1 to direction gives no halt
        do_write(2'd1, 8'h80, h);
        check("R7 no halt on dir write", {7'd0, h}, 8'h00);
        check("R4 dir bit7 dropped", pad_oe, 8'h00);

        // R8 input-only pins with value bits set
        do_write(2'd1, 8'hC0, h);
        do_write(2'd0, 8'hC0, h);
        check("R8 no oe", pad_oe, 8'h00);
        check("R8 no pull", pad_pull_en, 8'h00);
        do_read(2'd0, rd); check("R3 bit7 readback", rd, 8'hC0);

        // R5 synchronizer delay
        addr = 2'd2;
        @(negedge clk); pin_in = 8'h5A;
        @(negedge clk); check("R5 after one edge", rdata, 8'h00);
        @(negedge clk); check("R5 after two edges", rdata, 8'h5A);
        pin_in = 8'hE1;
        @(negedge clk); check("R5 change hidden", rdata, 8'h5A);
        @(negedge clk); check("R5 change seen", rdata, 8'hE1);

        // R1 reset again clears registers
        rst_n = 1'b0;
        @(negedge clk);
        do_read(2'd0, rd); check("R1 value after reset", rd, 8'h00);
        do_read(2'd2, rd); check("R1 pins after reset", rd, 8'h00);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule